// File: doc/BRIEF.md
# Matrix-Based Least-Recently-Used Frame Tracker

This block keeps the recency order of a parameterised number of page frames and names the one that has gone unused the longest. Recency lives in a square bit matrix with one row and one column for each frame. A touch strobe with a frame number marks that frame as the newest. A query strobe asks which frame should be evicted next.

A replacement controller drives the block. It touches a frame each time that frame is used and queries when it needs a frame to evict. The eviction candidate is the frame whose row, read as an unsigned number, is the smallest. The answer comes out in the same cycle or one cycle later, as a parameter selects. The answer always reflects the matrix as it stood before any touch made in the same cycle.

Top module: `lru_matrix_tracker`

## Requirements
- R1: While reset is asserted every matrix bit is 0, so a query made just after reset reports frame 0.
- R2: A touch of frame k sets every bit of row k except the bit in column k.
- R3: A touch of frame k clears every bit of column k, including the diagonal bit of row k.
- R4: The reported victim is the frame whose row has the smallest unsigned value, where row bit j belongs to column j and column 0 is the least significant bit. The reported victim is always below FRAMES.
- R5: When several rows share the smallest value, the lowest frame number is reported. As a result, frames never touched since reset are chosen first, lowest number first.
- R6: When a touch and a query occur in the same cycle, the victim is taken from the matrix before that touch is applied.
- R7: With VICTIM_LATENCY=1 (the default), victim_vld is high in exactly the cycle after a cycle with ask high, and the victim is held until the next query. With VICTIM_LATENCY=0, victim_vld follows ask in the same cycle.
- R8: Once every frame has been touched, victims follow the order of the touches, oldest first. For FRAMES of 2 or more, the frame touched most recently is never reported.
- R9: Touching the frame that is already the most recent leaves the victim order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the matrix |
| touch_en | input | 1 | Touch strobe: the frame on touch_idx becomes the newest |
| touch_idx | input | IW | Frame number that is touched |
| ask | input | 1 | Query strobe for the eviction candidate |
| victim | output | IW | Frame number of the eviction candidate |
| victim_vld | output | 1 | High when victim holds the answer to a query |

## Verification
The block is driven with four kinds of touch pattern. Ascending fills show that untouched frames win ties by lowest number. Descending fills check the ordering in the other direction. Repeated touches of one frame check that order does not change. Long pseudo-random streams of touches and queries catch row or column updates that go wrong only in some pairs of frames. Queries made in the same cycle as a touch of the current victim tell a pre-update answer from a post-update one. The bench model keeps a plain recency list, so any difference in the ranking of the matrix rows shows up as a wrong victim.

// File: rtl/lru_mx_pkg.sv
`timescale 1ns/1ps
package lru_mx_pkg;
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/lru_mx_store.sv
`timescale 1ns/1ps
module lru_mx_store #(
   parameter int FRAMES = 4,
   parameter int IW     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     touch_en,
   input  logic [IW-1:0]            touch_idx,
   output logic [FRAMES*FRAMES-1:0] rows_flat
);
   // Row r occupies rows_flat[r*FRAMES +: FRAMES]; bit c of a row is column c.
   for (genvar r = 0; r < FRAMES; r++) begin : g_row
      for (genvar c = 0; c < FRAMES; c++) begin : g_col
         logic cell_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cell_q <= 1'b0;
            else if (touch_en && (touch_idx == IW'(c)))
               cell_q <= 1'b0;
            else if (touch_en && (touch_idx == IW'(r)))
               cell_q <= 1'b1;
         end
         assign rows_flat[r*FRAMES + c] = cell_q;
      end
   end
endmodule

// File: rtl/lru_mx_argmin.sv
`timescale 1ns/1ps
module lru_mx_argmin #(
   parameter int FRAMES = 4,
   parameter int IW     = 2
) (
   input  logic [FRAMES*FRAMES-1:0] rows_flat,
   output logic [IW-1:0]            min_idx
);
   logic [FRAMES-1:0] best_row;

   always_comb begin
      min_idx  = '0;
      best_row = rows_flat[FRAMES-1:0];
      for (int i = 1; i < FRAMES; i++) begin
         // strict compare keeps the lowest index on ties
         if (rows_flat[i*FRAMES +: FRAMES] < best_row) begin
            best_row = rows_flat[i*FRAMES +: FRAMES];
            min_idx  = IW'(i);
         end
      end
   end
endmodule

// File: rtl/lru_matrix_tracker.sv
`timescale 1ns/1ps
module lru_matrix_tracker #(
   parameter int FRAMES         = 4,
   parameter int VICTIM_LATENCY = 1,
   localparam int IW            = lru_mx_pkg::idx_width(FRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   input  logic          ask,
   output logic [IW-1:0] victim,
   output logic          victim_vld
);
   if (FRAMES < 2) begin : g_bad_frames
      $error("lru_matrix_tracker: FRAMES must be at least 2");
   end
   if (VICTIM_LATENCY < 0 || VICTIM_LATENCY > 1) begin : g_bad_lat
      $error("lru_matrix_tracker: VICTIM_LATENCY must be 0 or 1");
   end

   logic [FRAMES*FRAMES-1:0] rows_flat;
   logic [IW-1:0]            min_idx;

   lru_mx_store #(.FRAMES(FRAMES), .IW(IW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .rows_flat (rows_flat)
   );

   lru_mx_argmin #(.FRAMES(FRAMES), .IW(IW)) u_argmin (
      .rows_flat (rows_flat),
      .min_idx   (min_idx)
   );

   if (VICTIM_LATENCY == 0) begin : g_comb
      assign victim     = min_idx;
      assign victim_vld = ask;
   end else begin : g_reg
      logic [IW-1:0] victim_q;
      logic          vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            victim_q <= '0;
            vld_q    <= 1'b0;
         end else begin
            vld_q <= ask;
            if (ask) victim_q <= min_idx;
         end
      end
      assign victim     = victim_q;
      assign victim_vld = vld_q;
   end
endmodule

// File: rtl/lru_mx_checker.sv
`timescale 1ns/1ps
module lru_mx_checker #(
   parameter int FRAMES         = 4,
   parameter int VICTIM_LATENCY = 1,
   localparam int IW            = lru_mx_pkg::idx_width(FRAMES)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     touch_en,
   input logic [IW-1:0]            touch_idx,
   input logic                     ask,
   input logic [IW-1:0]            victim,
   input logic                     victim_vld,
   input logic [FRAMES*FRAMES-1:0] rows_flat
);
   logic [1:0] live;
   always_ff @(posedge clk) begin
      if (!rst_n) live <= '0;
      else if (live != 2'd3) live <= live + 2'd1;
   end

   function automatic logic [FRAMES-1:0] col_bits(input logic [FRAMES*FRAMES-1:0] rf,
                                                   input logic [IW-1:0] c);
      logic [FRAMES-1:0] v;
      for (int r = 0; r < FRAMES; r++) v[r] = rf[r*FRAMES + int'(c)];
      return v;
   endfunction

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> rows_flat == '0); // R1

   AST_ROW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> rows_flat[$past(touch_idx)*FRAMES +: FRAMES]
                   == ({FRAMES{1'b1}} ^ (FRAMES'(1) << $past(touch_idx)))); // R2

   AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> col_bits(rows_flat, $past(touch_idx)) == '0); // R3

   AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> int'(victim) < FRAMES); // R4

   if (VICTIM_LATENCY == 0) begin : g_a0
      AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         victim_vld == ask); // R7
      AST_MRU_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
         (live != 2'd0) && $past(touch_en) && victim_vld |-> victim != $past(touch_idx)); // R8
   end else begin : g_a1
      AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (live != 2'd0) |-> victim_vld == $past(ask)); // R7
      AST_MRU_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
         (live >= 2'd2) && $past(touch_en, 2) && victim_vld |-> victim != $past(touch_idx, 2)); // R8
   end
endmodule

bind lru_matrix_tracker lru_mx_checker #(
   .FRAMES(FRAMES), .VICTIM_LATENCY(VICTIM_LATENCY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .touch_en   (touch_en),
   .touch_idx  (touch_idx),
   .ask        (ask),
   .victim     (victim),
   .victim_vld (victim_vld),
   .rows_flat  (rows_flat)
);

// File: tb/tb_lru_matrix_tracker.sv
`timescale 1ns/1ps
module tb_lru_matrix_tracker;
   localparam int FRAMES = 4;
   localparam int IW     = lru_mx_pkg::idx_width(FRAMES);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          touch_en = 1'b0;
   logic [IW-1:0] touch_idx = '0;
   logic          ask = 1'b0;
   logic [IW-1:0] victim;
   logic          victim_vld;

   int total = 0;
   int bad   = 0;

   // behavioural model: recency list, oldest at the front
   int order[$];
   bit touched[FRAMES];

   always #10 clk = ~clk;

   lru_matrix_tracker #(.FRAMES(FRAMES), .VICTIM_LATENCY(1)) dut (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
      .ask(ask), .victim(victim), .victim_vld(victim_vld)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_victim();
      for (int i = 0; i < FRAMES; i++) if (!touched[i]) return i;
      return order[0];
   endfunction

   function automatic void model_touch(input int k);
      for (int i = 0; i < order.size(); i++)
         if (order[i] == k) begin order.delete(i); break; end
      order.push_back(k);
      touched[k] = 1'b1;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; touch_en = 1'b0; ask = 1'b0;
      order.delete();
      for (int i = 0; i < FRAMES; i++) touched[i] = 1'b0;
      repeat (2) @(negedge clk);
      check(victim_vld == 1'b0, "R1 vld in reset", int'(victim_vld), 0);
      check(victim == '0, "R1 victim in reset", int'(victim), 0);
      rst_n = 1'b1;
   endtask

   // called at a negedge; drives one cycle and compares at the next negedge
   task automatic step(input bit te, input int ti, input bit q, input string req);
      bit exp_vld;
      int exp_vic;
      touch_en  = te;
      touch_idx = IW'(ti);
      ask       = q;
      exp_vld   = q;
      exp_vic   = q ? model_victim() : 0;   // pre-update state (R6)
      if (te) model_touch(ti);
      @(posedge clk);
      @(negedge clk);
      touch_en = 1'b0;
      ask      = 1'b0;
      check(victim_vld == exp_vld, {req, " vld (R7)"}, int'(victim_vld), int'(exp_vld));
      if (exp_vld) check(int'(victim) == exp_vic, req, int'(victim), exp_vic);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: first query after reset gives frame 0
      step(0, 0, 1, "R1 post-reset query");
      // R5: untouched frames win ties, lowest first
      step(1, 2, 0, "R5 touch");
      step(0, 0, 1, "R5 lowest untouched");
      step(1, 0, 0, "R5 touch");
      step(0, 0, 1, "R5 next untouched");
      // R6: query while touching the current victim
      step(1, 1, 1, "R6 same-cycle query");
      step(0, 0, 1, "R6 after touch");
      // R8: ascending fill then drain order
      do_reset();
      for (int i = 0; i < FRAMES; i++) step(1, i, 0, "R2 fill asc");
      for (int i = 0; i < FRAMES; i++) begin
         step(0, 0, 1, "R8 oldest first");
         step(1, model_victim(), 0, "R3 retouch victim");
      end
      // descending fill
      do_reset();
      for (int i = FRAMES - 1; i >= 0; i--) step(1, i, 0, "R2 fill desc");
      step(0, 0, 1, "R4 desc victim");
      // R9: repeated touch of the newest frame
      step(1, 0, 0, "R9 touch");
      step(1, 0, 0, "R9 touch again");
      step(0, 0, 1, "R9 order kept");
      step(1, 0, 1, "R9 touch+query");
      step(0, 0, 1, "R9 order kept 2");
      // pseudo-random stream
      do_reset();
      for (int n = 0; n < 600; n++) begin
         int r;
         r = $urandom;
         step(r[0] | r[1], (r >> 4) % FRAMES, r[2], "R4/R5 random");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule